// File: doc/BRIEF.md
# Majority-Vote Sample Filter

This block recovers a trustworthy word from a register source whose reads sometimes return garbage. When started, it takes a fixed number of samples of the source word. It then counts how often each distinct value appears and returns the value seen most often. Storage and counting are separate phases. First every sample is written into a local buffer. Then the buffer is replayed one entry per clock into a table of distinct values, where each value has an occurrence counter.

The tally ends early as soon as one value's count passes half of the sample total, because no other value can overtake it after that point. Otherwise the tally runs to the end of the buffer and the leading value is returned. The leader changes only when a count rises strictly above the current best. On equal counts, the value that reached that count first is kept. When the result is ready, a one-cycle flag is raised and the result output holds the word until the next read completes.

Top module: `majority_read_filter`

## Requirements
- R1: While reset is applied, and immediately after it, `done_o` is 0 and `result_o` is 0.
- R2: A read starts on a `start_i` pulse while the block is idle. It then accepts exactly NUM_SAMPLES (100) words, one on each cycle in which `smp_valid_i` is high. `smp_valid_i` asserted before the start is ignored.
- R3: Once all samples are captured, the buffer is tallied one sample per cycle in capture order. The tally stops at the first sample that raises a value's count above NUM_SAMPLES/2, and that value is returned. A count of exactly 50 does not end the tally. `done_o` rises k+1 cycles after the clock edge that accepted the last sample, where k is the 0-based index of the sample that ended the tally.
- R4: If no value reaches a majority, all samples are tallied (`done_o` 100 cycles after the last accepted sample). The value with the highest count is returned.
- R5: On equal counts, the leader is replaced only by a strictly higher count, so the value that first reached the winning count is returned.
- R6: `done_o` is high for exactly one cycle per read. `result_o` changes only in the cycle `done_o` rises and holds its value until the next completion.
- R7: A `start_i` pulse during capture or tally is ignored: the running read completes with its own samples and timing.
- R8: `smp_valid_i` and `smp_data_i` during the tally phase are ignored.
- R9: Each new read clears the value table and the leader, so its result depends only on its own samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a read (accepted only while idle) |
| smp_valid_i | input | 1 | Sample word present on `smp_data_i` |
| smp_data_i | input | DATA_W | Sampled source word |
| result_o | output | DATA_W | Filtered (most frequent) value |
| done_o | output | 1 | One-cycle pulse: `result_o` updated |

## Verification
The assertions assume that `start_i` arrives only as the trigger for a whole read, and that every accepted read is eventually fed its full sample count. Otherwise capture would stall and no completion would follow. They also rely on the table leader never exceeding the majority threshold plus one, which holds only if the sequencer stops the tally at the majority sample. The stimulus feeds exactly one hundred valid words per read, one per cycle. It deliberately places a stray start inside capture and tally, junk valid words before the start, and junk words during the tally, so that the ignore rules are exercised without ever starving a read.

// File: rtl/mvf_pkg.sv
package mvf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_TALLY   = 2'd2
    } mvf_state_e;

    // Count that a value must exceed to hold a strict majority
    function automatic int unsigned majority_limit(int unsigned n);
        return n / 2;
    endfunction

endpackage

// File: rtl/mvf_sample_store.sv
module mvf_sample_store #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 100,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/mvf_tally_table.sv
module mvf_tally_table #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SLOTS  = 100,
    localparam int unsigned CNT_W = $clog2(SLOTS + 1),
    localparam int unsigned SA_W  = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              upd_i,
    input  logic [DATA_W-1:0] smp_i,
    output logic [CNT_W-1:0]  cnt_next_o,
    output logic [CNT_W-1:0]  lead_cnt_o,
    output logic [DATA_W-1:0] lead_val_o
);

    logic [DATA_W-1:0] slot_val_q [SLOTS];
    logic [CNT_W-1:0]  slot_cnt_q [SLOTS];
    logic [CNT_W-1:0]  used_q;
    logic [SLOTS-1:0]  hit_vec;
    logic              hit;
    logic [SA_W-1:0]   hit_idx;
    logic [SA_W-1:0]   tgt_idx;

    // One comparator per slot; an empty slot (count 0) never matches
    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign hit_vec[g] = (slot_cnt_q[g] != '0) && (slot_val_q[g] == smp_i);
    end

    // Lowest matching slot; distinct values occupy distinct slots
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int j = SLOTS - 1; j >= 0; j--) begin
            if (hit_vec[j]) begin
                hit     = 1'b1;
                hit_idx = SA_W'(j);
            end
        end
    end

    // A miss takes the first free slot, which is the fill level
    assign tgt_idx    = hit ? hit_idx : SA_W'(used_q);
    assign cnt_next_o = hit ? slot_cnt_q[hit_idx] + 1'b1 : CNT_W'(1);

    always_ff @(posedge clk) begin
        if (upd_i) begin
            slot_val_q[tgt_idx] <= smp_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            for (int k = 0; k < SLOTS; k++) begin
                slot_cnt_q[k] <= '0;
            end
            used_q     <= '0;
            lead_cnt_o <= '0;
            lead_val_o <= '0;
        end else if (upd_i) begin
            slot_cnt_q[tgt_idx] <= cnt_next_o;
            if (!hit) begin
                used_q <= used_q + 1'b1;
            end
            if (cnt_next_o > lead_cnt_o) begin
                lead_cnt_o <= cnt_next_o;
                lead_val_o <= smp_i;
            end
        end
    end

    // R3: the sequencer stops at the majority sample, so the leader never overshoots
    p_lead_bound_r3: assert property (@(posedge clk) disable iff (rst)
        lead_cnt_o <= CNT_W'(mvf_pkg::majority_limit(SLOTS) + 1));

    // R5: within one read the leader count only grows, by at most one per update
    p_lead_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!clear_i && upd_i) |=> (lead_cnt_o == $past(lead_cnt_o)) ||
                                (lead_cnt_o == $past(lead_cnt_o) + 1'b1));

endmodule

// File: rtl/majority_read_filter.sv
module majority_read_filter #(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned NUM_SAMPLES = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              smp_valid_i,
    input  logic [DATA_W-1:0] smp_data_i,
    output logic [DATA_W-1:0] result_o,
    output logic              done_o
);
    import mvf_pkg::*;

    localparam int unsigned IDX_W = $clog2(NUM_SAMPLES);
    localparam int unsigned CNT_W = $clog2(NUM_SAMPLES + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SAMPLES - 1);
    localparam logic [CNT_W-1:0] MAJ_LIM  = CNT_W'(majority_limit(NUM_SAMPLES));

    mvf_state_e        st_q;
    logic [IDX_W-1:0]  wr_idx_q;
    logic [IDX_W-1:0]  rd_idx_q;
    logic [DATA_W-1:0] rd_data;
    logic [CNT_W-1:0]  cnt_next;
    logic [CNT_W-1:0]  lead_cnt;
    logic [DATA_W-1:0] lead_val;

    logic accept_start, cap_we, cap_last, tally_en, is_maj, finish;
    logic [DATA_W-1:0] winner;

    assign accept_start = (st_q == ST_IDLE) && start_i;
    assign cap_we       = (st_q == ST_CAPTURE) && smp_valid_i;
    assign cap_last     = cap_we && (wr_idx_q == LAST_IDX);
    assign tally_en     = (st_q == ST_TALLY);
    assign is_maj       = cnt_next > MAJ_LIM;
    assign finish       = tally_en && (is_maj || (rd_idx_q == LAST_IDX));
    assign winner       = (cnt_next > lead_cnt) ? rd_data : lead_val;

    mvf_sample_store #(
        .DATA_W (DATA_W),
        .DEPTH  (NUM_SAMPLES)
    ) u_store (
        .clk     (clk),
        .wr_en   (cap_we),
        .wr_addr (wr_idx_q),
        .wr_data (smp_data_i),
        .rd_addr (rd_idx_q),
        .rd_data (rd_data)
    );

    mvf_tally_table #(
        .DATA_W (DATA_W),
        .SLOTS  (NUM_SAMPLES)
    ) u_table (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (accept_start),
        .upd_i      (tally_en),
        .smp_i      (rd_data),
        .cnt_next_o (cnt_next),
        .lead_cnt_o (lead_cnt),
        .lead_val_o (lead_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            wr_idx_q <= '0;
            rd_idx_q <= '0;
            result_o <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (accept_start) begin
                        wr_idx_q <= '0;
                        st_q     <= ST_CAPTURE;
                    end
                end
                ST_CAPTURE: begin
                    if (cap_we) begin
                        wr_idx_q <= wr_idx_q + 1'b1;
                    end
                    if (cap_last) begin
                        rd_idx_q <= '0;
                        st_q     <= ST_TALLY;
                    end
                end
                ST_TALLY: begin
                    rd_idx_q <= rd_idx_q + 1'b1;
                    if (finish) begin
                        result_o <= winner;
                        done_o   <= 1'b1;
                        st_q     <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R6: completion flag lasts one cycle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6: the result moves only together with the completion flag
    p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(result_o));

    // R2: an idle start opens capture
    p_start_capture_r2: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_IDLE) && start_i) |=> (st_q == ST_CAPTURE));

    // R7: a start seen in capture does not rewind the write index
    p_busy_start_r7: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_CAPTURE) && start_i && !smp_valid_i) |=> $stable(wr_idx_q));

    // R3: the tally walks the buffer one entry per cycle
    p_tally_step_r3: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_TALLY) && !finish) |=>
            ((st_q == ST_TALLY) && (rd_idx_q == $past(rd_idx_q) + 1'b1)));

    // R4: completion only comes out of the tally phase
    p_done_source_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(st_q) == ST_TALLY));

endmodule

// File: tb/test_majority_read_filter.sv
`timescale 1ns/1ps
module test_majority_read_filter;

    localparam int N = 100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        smp_valid_i = 1'b0;
    logic [31:0] smp_data_i = '0;
    logic [31:0] result_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] stim [N];

    always #2.5 clk = ~clk;

    majority_read_filter #(.DATA_W(32), .NUM_SAMPLES(N)) i_majority_read_filter (
        .clk(clk), .rst(rst), .start_i(start_i), .smp_valid_i(smp_valid_i),
        .smp_data_i(smp_data_i), .result_o(result_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Reference: tally in order, strict-greater leader update, stop above N/2
    task automatic model(output logic [31:0] val, output int stop);
        logic [31:0] tv [N];
        int          tc [N];
        int used = 0, best = 0;
        logic [31:0] bv = '0;
        stop = N - 1;
        for (int i = 0; i < N; i++) begin
            int j = -1;
            for (int k = 0; k < used; k++) if (j < 0 && tv[k] == stim[i]) j = k;
            if (j < 0) begin j = used; tv[j] = stim[i]; tc[j] = 0; used++; end
            tc[j]++;
            if (tc[j] > best) begin best = tc[j]; bv = stim[i]; end
            if (best > N / 2) begin stop = i; break; end
        end
        val = bv;
    endtask

    task automatic run_read(input string tag, input bit inj_start, input bit junk_tally);
        logic [31:0] ev;
        int es, lat;
        model(ev, es);
        // R2: junk valid words while idle must not be taken
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); smp_valid_i = 1'b1; smp_data_i = $urandom;
        end
        @(negedge clk); smp_valid_i = 1'b0; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int i = 0; i < N; i++) begin
            smp_valid_i = 1'b1;
            smp_data_i  = stim[i];
            start_i     = inj_start && (i == 50);   // R7
            @(negedge clk);
        end
        smp_valid_i = 1'b0; start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 1000) begin
            if (junk_tally) begin                   // R8
                smp_valid_i = 1'b1; smp_data_i = $urandom;
                start_i = inj_start && (lat == 3);  // R7
            end
            @(negedge clk);
            lat++;
        end
        smp_valid_i = 1'b0; start_i = 1'b0;
        if (lat >= 1000) begin
            check(1'b0, {tag, " watchdog no done"}, 32'(lat), 32'(es + 1));
        end else begin
            check(result_o == ev, {tag, " result"}, result_o, ev);
            check(lat == es + 1, {tag, " latency R3 R4"}, 32'(lat), 32'(es + 1));
            @(negedge clk);
            check(done_o == 1'b0, {tag, " done pulse R6"}, 32'(done_o), 32'd0);
            check(result_o == ev, {tag, " result hold R6"}, result_o, ev);
        end
    endtask

    task automatic fill_random(input int dom);
        logic [31:0] pool [4];
        for (int p = 0; p < 4; p++) pool[p] = $urandom;
        for (int i = 0; i < N; i++) begin
            if ($urandom_range(99, 0) < dom) stim[i] = pool[0];
            else stim[i] = pool[1 + $urandom_range(2, 0)];
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check(done_o == 1'b0, "R1 done in reset", 32'(done_o), 32'd0);
        check(result_o == '0, "R1 result in reset", result_o, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(done_o == 1'b0, "R1 done after reset", 32'(done_o), 32'd0);
        check(result_o == '0, "R1 result after reset", result_o, 32'd0);

        // R3: all equal, majority at sample index 50
        for (int i = 0; i < N; i++) stim[i] = 32'hA5A5_0001;
        run_read("R3 all equal", 1'b0, 1'b0);

        // R3: exactly 50 is no majority; R5 tie keeps the first leader
        for (int i = 0; i < N; i++) stim[i] = (i < 50) ? 32'h0000_00AA : 32'h0000_00BB;
        run_read("R3 R5 fifty fifty", 1'b0, 1'b0);

        // R3: majority reached only on the final sample
        for (int i = 0; i < N; i++) stim[i] = (i < 49) ? 32'h1111_2222 : 32'h3333_4444;
        run_read("R3 late majority", 1'b0, 1'b0);

        // R5: second value reaches the tie count later and loses
        stim[0] = 32'hD0D0_D0D0;
        for (int i = 1; i <= 40; i++) stim[i] = 32'hC0C0_C0C0;
        for (int i = 41; i <= 79; i++) stim[i] = 32'hD0D0_D0D0;
        for (int i = 80; i < N; i++) stim[i] = 32'hE000_0000 + 32'(i);
        run_read("R5 tie order", 1'b0, 1'b0);

        // R4: plurality without majority
        for (int i = 0; i < N; i++) stim[i] = (i % 3 == 0) ? 32'h7 : ((i % 3 == 1) ? 32'h8 : 32'h9);
        run_read("R4 plurality", 1'b0, 1'b0);

        // R9: a majority read followed by all-distinct values
        for (int i = 0; i < N; i++) stim[i] = 32'hFACE_0000;
        run_read("R9 first read", 1'b0, 1'b0);
        for (int i = 0; i < N; i++) stim[i] = 32'h5000_0000 + 32'(i * 7);
        run_read("R9 R4 all distinct", 1'b0, 1'b0);

        // R7 R8: stray start and junk during capture and tally
        fill_random(60);
        run_read("R7 R8 stray inputs", 1'b1, 1'b1);
        fill_random(35);
        run_read("R7 R8 stray inputs low dom", 1'b1, 1'b1);

        // R2 R3 R4: constrained random reads
        for (int t = 0; t < 8; t++) begin
            fill_random($urandom_range(85, 20));
            run_read("R2 random", t[0], t[1]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule